// File: doc/BRIEF.md
# I2C Stuck-Bus Release Sequencer

This block frees an I2C bus that a slave device is still holding, typically after a transfer was cut off in the middle of a byte. The slave keeps SDA low because it expects more clock edges. On a trigger, the sequencer first waits, for a bounded time, for the bus controller to stop reporting busy. It then decides whether recovery is needed: recovery runs if the controller is still busy or if SDA reads low. During recovery the sequencer takes over the pins from the controller. It pulls SCL low for one interval, then issues clock pulses, testing SDA before each one. It stops at the first high reading of SDA, or after a fixed maximum number of pulses. It then lets SCL float high for one interval and hands the pins back. A one-cycle done pulse ends every run, and a fail flag tells whether SDA was still held low after the last allowed pulse.

All pin outputs are open-drain requests: a 1 on a `*_pull` signal means drive the line low, and a 0 means release it so that it floats high. The states are IDLE (waiting for a trigger), WAIT_IDLE (bounded poll of the busy indication), CHECK (one-cycle recovery decision), PRE_LOW (SCL held low for one interval), TEST (one-cycle SDA test with SCL low), PULSE_HI and PULSE_LO (the two halves of one clock pulse, one interval each), RELEASE (SCL released for one interval) and FINISH (one-cycle done, pins back with the controller). The transitions are as follows:
- IDLE to WAIT_IDLE on a trigger.
- WAIT_IDLE to CHECK when busy reads low, or when the poll budget runs out.
- CHECK to PRE_LOW when recovery is needed, otherwise to FINISH.
- PRE_LOW to TEST when its interval expires.
- TEST to RELEASE when SDA is high or the pulse budget is used up, otherwise to PULSE_HI.
- PULSE_HI to PULSE_LO, then PULSE_LO back to TEST, each when its interval expires.
- RELEASE to FINISH when its interval expires.
- FINISH to IDLE unconditionally.

The interval length, the poll step length, the number of poll steps and the pulse budget are all parameters. Their defaults correspond to 1 ms steps, a 1 s poll budget at 125 MHz, and 10 pulses.

Top module: `i2c_unstick_top`

## Requirements
- R1: After reset the sequencer is idle. `pin_own`, `done` and `fail` are 0, and `scl_pull`/`sda_pull` equal `ctrl_scl_pull`/`ctrl_sda_pull`.
- R2: After a trigger the sequencer stays in its busy poll while `ctrl_busy` is 1, for at most POLL_STEPS*POLL_STEP_CYC cycles. It leaves on the edge at which it sees `ctrl_busy` at 0.
- R3: Recovery, with `pin_own`=1, happens only if `ctrl_busy` is 1 or `sda_in` is 0 in the cycle after the poll. Otherwise `done` follows with `pin_own` never raised and `fail`=0.
- R4: When recovery starts, SCL is pulled low for INTERVAL_CYC cycles, and SDA is then tested in one further cycle with SCL still low, so the first low phase lasts INTERVAL_CYC+1 cycles.
- R5: Each clock pulse releases SCL for INTERVAL_CYC cycles and then pulls it low for INTERVAL_CYC cycles plus the one test cycle. SDA is tested before every pulse, and no further pulse follows a high reading. The number of pulses is min(K, MAX_PULSES), where K is the number of SCL rising edges the slave needs before it releases SDA.
- R6: After the last test, SCL is released for INTERVAL_CYC cycles while the sequencer still owns the pins. Ownership then drops with SCL released.
- R7: `done` is 1 for exactly one cycle per run. Counting cycles from the trigger edge, it rises after W+2 cycles without recovery and after W+2*INTERVAL_CYC+3+n*(2*INTERVAL_CYC+1) cycles with recovery, where W is the length of the poll and n is the number of pulses.
- R8: `fail` is set if and only if SDA still reads 0 at the test that follows the MAX_PULSES-th pulse. It holds its value until the next accepted trigger.
- R9: While `pin_own` is 1, `sda_pull` is 0 and the controller's `ctrl_scl_pull`/`ctrl_sda_pull` have no effect on the pins.
- R10: A trigger that arrives while a run is in progress is ignored, so the timing and the pulse count of that run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Trigger for a recovery run (single-cycle pulse) |
| ctrl_busy | input | 1 | Busy indication from the bus controller |
| sda_in | input | 1 | Synchronized sample of the SDA line (1 = high) |
| ctrl_scl_pull | input | 1 | Controller request to pull SCL low |
| ctrl_sda_pull | input | 1 | Controller request to pull SDA low |
| scl_pull | output | 1 | Pull SCL low (1) or release it (0) |
| sda_pull | output | 1 | Pull SDA low (1) or release it (0) |
| pin_own | output | 1 | 1 while the sequencer owns the pins |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | SDA still low after the final permitted pulse |

## Verification
The trigger is driven at a falling edge, and every output is sampled 1 ns after each later falling edge. This counts exactly one cycle per rising edge, and the count at which `done` is first seen is compared with the latency formula of R7, built from the bench's own model of the poll length and of the pulse count. The pin outputs are combinational from state and controller inputs, so they are checked in the same sample as the inputs driven at that edge. The slave model counts SCL rising edges at those samples and releases SDA at the next falling edge, which is at least one interval before the next SDA test. The lengths of the high and low phases and the number of rising edges are collected over the whole ownership window and checked once `done` has been seen, together with `fail` one cycle later.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_WAIT_IDLE = 4'd1,
        ST_CHECK     = 4'd2,
        ST_PRE_LOW   = 4'd3,
        ST_TEST      = 4'd4,
        ST_PULSE_HI  = 4'd5,
        ST_PULSE_LO  = 4'd6,
        ST_RELEASE   = 4'd7,
        ST_FINISH    = 4'd8
    } unstick_state_e;

    function automatic logic is_timed(unstick_state_e s);
        return (s == ST_PRE_LOW) || (s == ST_PULSE_HI) ||
               (s == ST_PULSE_LO) || (s == ST_RELEASE);
    endfunction

endpackage

// File: rtl/i2c_unstick_interval.sv
module i2c_unstick_interval #(
    parameter int LIMIT = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Down-counter: a restart makes the following LIMIT cycles the window,
    // and expire marks the last cycle of it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/i2c_unstick_count.sv
module i2c_unstick_count #(
    parameter int MAX = 10,
    localparam int VW = (MAX < 1) ? 1 : $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [VW-1:0] value,
    output logic          at_max
);
    localparam logic [VW-1:0] TOP = VW'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clear) begin
            value <= '0;
        end else if (inc && !at_max) begin
            value <= value + 1'b1;
        end
    end

    assign at_max = (value == TOP);

    // R5: the sequencer never asks a full counter to advance
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |-> !at_max)
        else $error("counter incremented past its limit");

endmodule

// File: rtl/i2c_unstick_top.sv
module i2c_unstick_top
    import i2c_unstick_pkg::*;
#(
    parameter int INTERVAL_CYC  = 125000,
    parameter int POLL_STEP_CYC = 125000,
    parameter int POLL_STEPS    = 1000,
    parameter int MAX_PULSES    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ctrl_busy,
    input  logic sda_in,
    input  logic ctrl_scl_pull,
    input  logic ctrl_sda_pull,
    output logic scl_pull,
    output logic sda_pull,
    output logic pin_own,
    output logic done,
    output logic fail
);
    localparam int SW = (POLL_STEPS < 1) ? 1 : $clog2(POLL_STEPS + 1);
    localparam int PW = (MAX_PULSES < 1) ? 1 : $clog2(MAX_PULSES + 1);
    localparam logic [SW-1:0] LAST_STEP = SW'(POLL_STEPS - 1);

    unstick_state_e state_q, state_d;

    logic          iv_restart, iv_expire;
    logic          poll_restart, poll_expire;
    logic          step_clear, step_inc, step_full;
    logic [SW-1:0] step_val;
    logic          pulse_clear, pulse_inc, pulse_full;
    logic [PW-1:0] pulse_val;
    logic          seq_scl_low;
    logic          poll_timeout;
    logic          fail_q;

    // ---------------- timers and counters ----------------
    i2c_unstick_interval #(.LIMIT(INTERVAL_CYC)) u_phase_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (iv_restart),
        .expire  (iv_expire)
    );

    i2c_unstick_interval #(.LIMIT(POLL_STEP_CYC)) u_poll_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (poll_restart),
        .expire  (poll_expire)
    );

    i2c_unstick_count #(.MAX(POLL_STEPS)) u_step_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (step_clear),
        .inc    (step_inc),
        .value  (step_val),
        .at_max (step_full)
    );

    i2c_unstick_count #(.MAX(MAX_PULSES)) u_pulse_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pulse_clear),
        .inc    (pulse_inc),
        .value  (pulse_val),
        .at_max (pulse_full)
    );

    assign poll_timeout = poll_expire && (step_val == LAST_STEP);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_IDLE;
            end
            ST_WAIT_IDLE: begin
                if (!ctrl_busy || poll_timeout) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = (ctrl_busy || !sda_in) ? ST_PRE_LOW : ST_FINISH;
            end
            ST_PRE_LOW: begin
                if (iv_expire) state_d = ST_TEST;
            end
            ST_TEST: begin
                state_d = (sda_in || pulse_full) ? ST_RELEASE : ST_PULSE_HI;
            end
            ST_PULSE_HI: begin
                if (iv_expire) state_d = ST_PULSE_LO;
            end
            ST_PULSE_LO: begin
                if (iv_expire) state_d = ST_TEST;
            end
            ST_RELEASE: begin
                if (iv_expire) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- timer and counter control ----------------
    always_comb begin
        iv_restart   = (state_d != state_q) && is_timed(state_d);
        poll_restart = ((state_q == ST_IDLE) && start) ||
                       ((state_q == ST_WAIT_IDLE) && poll_expire);
        step_clear   = (state_q == ST_IDLE) && start;
        step_inc     = (state_q == ST_WAIT_IDLE) && poll_expire &&
                       (state_d == ST_WAIT_IDLE) && !step_full;
        pulse_clear  = (state_q == ST_CHECK);
        pulse_inc    = (state_q == ST_PULSE_LO) && iv_expire;
    end

    // ---------------- fail flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if ((state_q == ST_IDLE) && start) begin
            fail_q <= 1'b0;
        end else if ((state_q == ST_TEST) && pulse_full && !sda_in) begin
            fail_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        pin_own     = 1'b0;
        seq_scl_low = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT_IDLE, ST_CHECK: begin
                pin_own = 1'b0;
            end
            ST_PRE_LOW, ST_TEST, ST_PULSE_LO: begin
                pin_own     = 1'b1;
                seq_scl_low = 1'b1;
            end
            ST_PULSE_HI, ST_RELEASE: begin
                pin_own     = 1'b1;
                seq_scl_low = 1'b0;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                pin_own = 1'b0;
            end
        endcase
        scl_pull = pin_own ? seq_scl_low : ctrl_scl_pull;
        sda_pull = pin_own ? 1'b0 : ctrl_sda_pull;
    end

    assign fail = fail_q;

    // ---------------- assertions ----------------
    // R7: done lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held for more than one cycle");

    // R8: fail only rises after a low SDA reading
    p_fail_low_sda_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> !$past(sda_in))
        else $error("fail set while SDA was high");

    // R4: taking the pins starts with SCL pulled low
    p_take_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_own) |-> scl_pull)
        else $error("ownership taken without SCL low");

    // R6: pins go back only after SCL was released
    p_return_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_own) |-> !$past(scl_pull))
        else $error("ownership returned with SCL low");

    // R5: a pulse high phase is always followed by a low phase while owned
    p_pulse_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE_HI && iv_expire) |=> (pin_own && scl_pull))
        else $error("pulse high phase not followed by low phase");

endmodule

// File: tb/i2c_unstick_top_tb_top.sv
module i2c_unstick_top_tb_top;
    localparam int D  = 6;
    localparam int PC = 4;
    localparam int PS = 5;
    localparam int MX = 10;
    localparam int T  = PC * PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ctrl_busy = 1'b0;
    logic sda_in = 1'b1;
    logic ctrl_scl_pull = 1'b0;
    logic ctrl_sda_pull = 1'b0;
    logic scl_pull, sda_pull, pin_own, done, fail;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    i2c_unstick_top #(
        .INTERVAL_CYC (D),
        .POLL_STEP_CYC(PC),
        .POLL_STEPS   (PS),
        .MAX_PULSES   (MX)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .ctrl_busy    (ctrl_busy),
        .sda_in       (sda_in),
        .ctrl_scl_pull(ctrl_scl_pull),
        .ctrl_sda_pull(ctrl_sda_pull),
        .scl_pull     (scl_pull),
        .sda_pull     (sda_pull),
        .pin_own      (pin_own),
        .done         (done),
        .fail         (fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_wait(input int drop);
        if (drop < 0) return T;
        if (drop == 0) return 1;
        return drop;
    endfunction

    function automatic int exp_pulses(input int k, input int drop);
        if (k == 0) return 0;
        return (k < MX) ? k : MX;
    endfunction

    function automatic int exp_latency(input int k, input int drop);
        int w;
        w = exp_wait(drop);
        if (drop >= 0 && k == 0) return w + 2;
        return w + 2 * D + 3 + exp_pulses(k, drop) * (2 * D + 1);
    endfunction

    // k: rising edges the slave needs before freeing SDA (0 = SDA free)
    // drop: -1 busy held, 0 busy low at trigger, else falling edge it drops
    // retrig: cycle count at which a second trigger is issued (0 = none)
    task automatic run_case(input int k, input int drop, input int retrig);
        int cyc, rises, hi_run, lo_first, bad_hi, mux_bad, lat;
        bit prev_own, prev_pull, seen_high, own_ever, done_seen, fail_at, recov;
        string lreq;
        recov = (drop < 0) || (k > 0);
        lreq = (retrig > 0) ? "R10" : ((drop > 0) ? "R2" : "R7");
        cyc = 0; rises = 0; hi_run = 0; lo_first = 0; bad_hi = 0; mux_bad = 0;
        lat = 0; prev_own = 0; prev_pull = 0; seen_high = 0; own_ever = 0;
        done_seen = 0; fail_at = 0;
        @(negedge clk);
        ctrl_busy = (drop != 0);
        sda_in = (k == 0);
        ctrl_sda_pull = 1'b1;
        start = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            start = (retrig > 0 && cyc == retrig);
            if (drop > 0 && cyc == drop) ctrl_busy = 1'b0;
            ctrl_scl_pull = 1'($urandom % 2);
            #1;
            if (pin_own) begin
                own_ever = 1;
                if (sda_pull !== 1'b0) mux_bad++;
                if (prev_own && prev_pull && !scl_pull) rises++;
                if (!scl_pull) begin
                    hi_run++;
                    seen_high = 1;
                end else begin
                    if (hi_run > 0 && hi_run != D) bad_hi++;
                    hi_run = 0;
                    if (!seen_high) lo_first++;
                end
            end else begin
                if (scl_pull !== ctrl_scl_pull || sda_pull !== ctrl_sda_pull) mux_bad++;
                if (prev_own) begin
                    if (hi_run != D) bad_hi++;
                    hi_run = 0;
                end
            end
            prev_own = pin_own;
            prev_pull = scl_pull;
            sda_in = (k == 0) ? 1'b1 : (rises >= k);
            if (done_seen) begin
                chk(done == 1'b0, "R7", "done width", int'(done), 0);
                chk(fail == fail_at, "R8", "fail held", int'(fail), int'(fail_at));
                break;
            end
            if (done) begin
                done_seen = 1;
                lat = cyc;
                fail_at = fail;
            end
            if (cyc > 3000) begin
                chk(1'b0, "R7", "watchdog on run", cyc, exp_latency(k, drop));
                break;
            end
        end
        start = 1'b0;
        chk(lat == exp_latency(k, drop), lreq, "latency", lat, exp_latency(k, drop));
        chk(own_ever == recov, "R3", "recovery taken", int'(own_ever), int'(recov));
        chk(rises == (recov ? exp_pulses(k, drop) + 1 : 0), "R5", "SCL rising edges",
            rises, recov ? exp_pulses(k, drop) + 1 : 0);
        chk(fail_at == (k > MX), "R8", "fail value", int'(fail_at), int'(k > MX));
        chk(mux_bad == 0, "R9", "pin mux violations", mux_bad, 0);
        if (recov) begin
            chk(lo_first == D + 1, "R4", "first low phase", lo_first, D + 1);
            chk(bad_hi == 0, "R6", "high phase widths", bad_hi, 0);
        end
        ctrl_busy = 1'b0;
        sda_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k, drop, rt;
        void'($urandom(32'd20240611));
        ctrl_scl_pull = 1'b1;
        ctrl_sda_pull = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(pin_own == 1'b0 && done == 1'b0 && fail == 1'b0, "R1", "reset outputs",
            {pin_own, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(scl_pull == ctrl_scl_pull && sda_pull == ctrl_sda_pull, "R1", "reset pin pass",
            {scl_pull, sda_pull}, {ctrl_scl_pull, ctrl_sda_pull});

        run_case(0, 0, 0);      // R3: nothing to recover
        run_case(0, -1, 0);     // R2/R3: busy stuck, SDA high
        run_case(1, 0, 0);      // R5: one pulse
        run_case(10, 0, 0);     // R8: frees on last pulse
        run_case(11, 0, 0);     // R8: still stuck
        run_case(12, 7, 0);     // R2: busy drops mid-poll
        run_case(3, 0, 9);      // R10: second trigger ignored
        run_case(0, 13, 0);     // R2: busy drops late, no recovery

        for (int i = 0; i < 24; i++) begin
            k = int'($urandom % 13);
            case ($urandom % 3)
                0: drop = 0;
                1: drop = 1 + int'($urandom % (T - 1));
                default: drop = -1;
            endcase
            rt = 0;
            if (((drop < 0) || (k > 0)) && ($urandom % 4 == 0))
                rt = exp_wait(drop) + 4;
            run_case(k, drop, rt);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule